// File: doc/BRIEF.md
# Period-Match Limit Timer

This block is an up-counter that runs at a chosen fraction of an instruction-rate clock enable. On every cycle it compares its count with a writable period value. When the two are equal, the block raises a shutdown/match output, which goes to a complementary output stage as a fault stop. On the next prescaled tick the counter returns to zero. Each match also advances a postscaler. After a programmed number of matches, the postscaler sets a sticky interrupt flag.

Other logic can pull the counter back to zero through an external reset request. A circuit that pulses this request often enough never lets the count reach the period, so the block acts as a hardware time limit on that circuit. Software reaches the block through a small register port. Address 0 is the counter and address 1 is the period. Address 2 is control: bit 7 is run, bits 6:5 are the prescale select and bits 3:0 are the postscale select. Address 3 is status, with the interrupt flag in bit 0. A sleep input freezes the block.

Top module: `limit_timer`

## Requirements
- R1: After reset the counter reads 00h, the period reads FFh, the interrupt flag is 0 and the match output is 0.
- R2: With run set and the prescale select s in control bits 6:5, the counter advances once every 4^s enabled ticks. Starting from a count of 0 with ticks on every cycle, the match output first asserts P*4^s cycles after the control write, where P is the period.
- R3: The match output is high exactly when run is set and the counter equals the period.
- R4: On the first prescaled tick after a match, the counter returns to 00h and does not advance.
- R5: With postscale select N in control bits 3:0, the interrupt flag sets on the (N+1)-th counted match.
- R6: The interrupt flag stays set until one of two things clears it: a write to address 3 with bit 0 equal to 0, or a one-cycle pulse on flag_clr. A write with bit 0 equal to 1 leaves it unchanged.
- R7: A write to the counter or to control restarts the prescaler count from zero, and also restarts the postscaler count.
- R8: An ext_rst pulse clears the counter on the next prescaled tick. If ext_rst falls before that tick, the reset stays pending until the tick.
- R9: If ext_rst coincides with a counter write, the written value is loaded and the reset is discarded.
- R10: While hold is high, the counter keeps its value.
- R11: While run is clear, the counter keeps its value and the match output stays low, even when the counter equals the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Instruction-rate clock enable |
| hold | input | 1 | Sleep: freezes counter and prescaler |
| ext_rst | input | 1 | External counter reset request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 period, 2 control, 3 status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Read data, combinational |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| shdn_o | output | 1 | Match / shutdown output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 2-bit prescale select and a 4-bit postscale select. These defaults make every divide ratio reachable, including divide-by-64, and so the prescaler-restart case can be measured. They also make the full FFh period and the period-zero case reachable within a short run. Postscale counts greater than one can be checked cycle-exactly in the same way.

// File: rtl/limit_timer_pkg.sv
package limit_timer_pkg;
  typedef enum logic [1:0] {
    A_CNT = 2'd0,
    A_PER = 2'd1,
    A_CTL = 2'd2,
    A_STS = 2'd3
  } lt_addr_e;
endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int SEL_W = 2,
  localparam int PS_W = 2 * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             adv
);
  // terminal count of the prescaler: ratio 4^sel minus one
  function automatic logic [PS_W-1:0] lim_of(input logic [SEL_W-1:0] s);
    lim_of = PS_W'((32'd1 << (2 * s)) - 32'd1);
  endfunction

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] lim;
  logic            at_lim;

  assign lim    = lim_of(sel);
  assign at_lim = (pcnt == lim);
  assign adv    = run && tick && at_lim && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)   pcnt <= '0;
    else if (run && tick)    pcnt <= at_lim ? '0 : pcnt + 1'b1;
  end

  // R2: prescaler count never passes its limit after a restart
  assert_psc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (restart) |=> (pcnt <= lim_of($past(sel)) || sel != $past(sel)));
  // R10: frozen prescaler while not running
  assert_psc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pcnt));
endmodule

// File: rtl/lt_count_core.sv
module lt_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ext_rst,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic pend_q;
  logic zap;

  assign hit = (cnt == period);
  assign zap = hit || pend_q || ext_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend_q <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      pend_q <= 1'b0;
    end else begin
      if (adv) cnt <= zap ? '0 : cnt + 1'b1;
      if (adv)          pend_q <= 1'b0;
      else if (ext_rst) pend_q <= 1'b1;
    end
  end

  assert_clear_after_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && hit && !load) |=> (cnt == '0));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !zap && !load) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(cnt));
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ext_rst) |=> (cnt == $past(load_val) && !pend_q));
endmodule

// File: rtl/lt_postscaler.sv
module lt_postscaler #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic [POST_W-1:0] lim,
  input  logic              restart,
  input  logic              clr,
  output logic              flag
);
  logic [POST_W-1:0] pcnt;
  logic              fire;

  assign fire = ev && (pcnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pcnt <= '0;
    else if (ev)           pcnt <= fire ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (fire) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !ev) |=> !flag);
endmodule

// File: rtl/limit_timer.sv
module limit_timer
  import limit_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 2,
  parameter int POST_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             hold,
  input  logic             ext_rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             flag_clr,
  output logic             shdn_o,
  output logic             irq_o
);
  localparam int RUN_B = CNT_W - 1;
  localparam int SEL_L = RUN_B - SEL_W;

  logic              on_q;
  logic [SEL_W-1:0]  sel_q;
  logic [POST_W-1:0] post_q;
  logic [CNT_W-1:0]  per_q;
  logic [CNT_W-1:0]  cnt;
  logic              hit, adv, run;
  logic              wr_cnt, wr_ctl, wr_per, wr_sts;
  logic              restart, flag_wipe, flag;

  assign wr_cnt    = wr_en && (wr_addr == A_CNT);
  assign wr_per    = wr_en && (wr_addr == A_PER);
  assign wr_ctl    = wr_en && (wr_addr == A_CTL);
  assign wr_sts    = wr_en && (wr_addr == A_STS);
  assign restart   = wr_cnt || wr_ctl;
  assign run       = on_q && !hold;
  assign flag_wipe = flag_clr || (wr_sts && !wr_data[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      sel_q  <= '0;
      post_q <= '0;
      per_q  <= '1;
    end else begin
      if (wr_ctl) begin
        on_q   <= wr_data[RUN_B];
        sel_q  <= wr_data[RUN_B-1:SEL_L];
        post_q <= wr_data[POST_W-1:0];
      end
      if (wr_per) per_q <= wr_data;
    end
  end

  lt_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_en),
    .sel(sel_q), .restart(restart), .adv(adv)
  );

  lt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(wr_cnt), .load_val(wr_data),
    .ext_rst(ext_rst), .period(per_q), .cnt(cnt), .hit(hit)
  );

  lt_postscaler #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst_n(rst_n), .ev(adv && hit), .lim(post_q),
    .restart(restart), .clr(flag_wipe), .flag(flag)
  );

  assign shdn_o = on_q && hit;
  assign irq_o  = flag;

  always_comb begin
    case (rd_addr)
      A_CNT:   rd_data = cnt;
      A_PER:   rd_data = per_q;
      A_CTL:   rd_data = CNT_W'({on_q, sel_q, 1'b0, post_q});
      default: rd_data = CNT_W'(flag);
    endcase
  end

  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_q && !wr_cnt) |=> ($stable(cnt) || on_q));
  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_cnt) |=> $stable(cnt));
endmodule

// File: tb/test_limit_timer.sv
`timescale 1ns/100ps
module test_limit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1, hold = 1'b0, ext_rst = 1'b0;
  logic       wr_en = 1'b0, flag_clr = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       shdn_o, irq_o;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  limit_timer i_limit_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hold(hold), .ext_rst(ext_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .flag_clr(flag_clr), .shdn_o(shdn_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act %0d exp below 100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a; #0.1; d = int'(rd_data);
  endtask

  task automatic cycles_until_match(output int n);
    n = 0;
    while (!shdn_o && n < 20000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic cycles_until_flag(output int n);
    n = 0;
    while (!irq_o && n < 20000) begin @(posedge clk); #1; n++; end
  endtask

  // period, prescale select, cycles to first match (P * 4^s)
  localparam int VEC[6][3] = '{
    '{5, 0, 5}, '{0, 0, 0}, '{3, 1, 12}, '{2, 2, 32}, '{1, 3, 64}, '{255, 0, 255}
  };

  initial begin
    int v, n;
    step(3);
    rst_n = 1'b1;
    #0.5;
    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 0);
    rd(2'd1, v); check("R1 period", v, 255);
    rd(2'd3, v); check("R1 flag", v, 0);
    check("R1 match", int'(shdn_o), 0);

    // R2 / R3: table walk over period and prescale
    for (int k = 0; k < 6; k++) begin
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'(VEC[k][0]));
      wr(2'd2, 8'h80 | 8'(VEC[k][1] << 5));
      cycles_until_match(n);
      check($sformatf("R2 vec%0d cycles", k), n, VEC[k][2]);
      rd(2'd0, v); check($sformatf("R3 vec%0d count==period", k), v, VEC[k][0]);
    end

    // R4: clear after match
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'd3); wr(2'd2, 8'h80);
    cycles_until_match(n);
    step(1);
    rd(2'd0, v); check("R4 count after match", v, 0);
    check("R3 match falls", int'(shdn_o), 0);

    // R5: postscale 2 -> third match; period 1 div1 -> flag seen at 6 cycles
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'd1); wr(2'd3, 8'h00);
    wr(2'd2, 8'h82);
    cycles_until_flag(n);
    check("R5 flag after 3 matches", n, 6);
    // R6 sticky and clear
    step(10);
    check("R6 flag sticky", int'(irq_o), 1);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h01);
    check("R6 write one keeps flag", int'(irq_o), 1);
    wr(2'd3, 8'h00);
    check("R6 write zero clears", int'(irq_o), 0);
    wr(2'd0, 8'h00); wr(2'd2, 8'h80);
    cycles_until_flag(n);
    wr(2'd2, 8'h00);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check("R6 strobe clears", int'(irq_o), 0);

    // R11: off, count equals period
    wr(2'd0, 8'd5); wr(2'd1, 8'd5);
    check("R11 match low when off", int'(shdn_o), 0);
    step(5);
    rd(2'd0, v); check("R11 count held", v, 5);

    // R10: hold freezes
    wr(2'd1, 8'd200); wr(2'd0, 8'h00);
    hold = 1'b1;
    wr(2'd2, 8'h80);
    step(10);
    rd(2'd0, v); check("R10 held at 0", v, 0);
    hold = 1'b0;
    step(3);
    rd(2'd0, v); check("R10 resumes", v, 3);

    // R8: ext reset, div1 immediate
    ext_rst = 1'b1; step(1); ext_rst = 1'b0;
    rd(2'd0, v); check("R8 div1 clear", v, 0);
    // R8: div4 pending
    wr(2'd2, 8'hA0);
    wr(2'd0, 8'd10);
    step(1);
    ext_rst = 1'b1; step(1); ext_rst = 1'b0;
    rd(2'd0, v); check("R8 pending not yet", v, 10);
    step(1);
    rd(2'd0, v); check("R8 pending before tick", v, 10);
    step(1);
    rd(2'd0, v); check("R8 pending applied", v, 0);

    // R9: write wins over ext reset
    ext_rst = 1'b1;
    wr(2'd0, 8'd7);
    ext_rst = 1'b0;
    rd(2'd0, v); check("R9 loaded", v, 7);
    step(4);
    rd(2'd0, v); check("R9 reset discarded", v, 8);

    // R7: control write restarts prescaler (div64)
    wr(2'd2, 8'hE0);
    wr(2'd0, 8'h00);
    step(30);
    wr(2'd2, 8'hE0);
    step(63);
    rd(2'd0, v); check("R7 no early tick", v, 0);
    step(1);
    rd(2'd0, v); check("R7 tick after full ratio", v, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule